// File: doc/BRIEF.md
# Slave Address Match and Acknowledge Decision

This block sits beside the byte shifter of a two-wire serial bus controller. It examines the first byte received after a start or repeated start. Bits 7..1 of that byte are compared against a programmed 7-bit own address. The full byte is also checked against the all-zero broadcast address, which counts only when a broadcast-enable bit is set. A hit marks the device as addressed and latches the direction bit. It also raises a one-cycle match event, which the surrounding logic uses to raise its interrupt flag.

For every received byte the block also decides whether the controller drives an acknowledge. An address hit is acknowledged. A data byte is acknowledged in master-receiver mode, and in slave-receiver mode once the device has been addressed. A single acknowledge-enable bit can turn all of this off. While it is low, the device ignores its address and answers every byte with NACK, but stays enabled. Writing the bit high again resumes address recognition.

When a master loses arbitration during the address byte, the byte it received is still compared. This lets it become a slave without losing that byte. Stop, repeated start and a slave recovery command all drop the addressed state.

Top module: `i2c_addr_ack`

## Requirements
- R1: After reset, addressed_o, gen_call_o, rw_o, match_o and ack_o are all 0.
- R2: This requirement covers the first byte_valid_i after start_i, with mode_i a slave or idle code and ack_en_i = 1. When rx_byte_i[7:1] equals own_addr_i[7:1], the cycle after the byte gives addressed_o = 1, ack_o = 1, rw_o = rx_byte_i[0], and a single-cycle match_o.
- R3: An address byte equal to 8'h00 is a broadcast hit only when own_addr_i[0] = 1 (with ack_en_i = 1). A hit sets addressed_o, gen_call_o, ack_o and match_o. With own_addr_i[0] = 0 the same byte gives no match and ack_o = 0. The own address is never 0.
- R4: With ack_en_i = 0, an address byte never matches, addressed_o becomes 0 and ack_o = 0. Data bytes are also answered with ack_o = 0. Raising ack_en_i again makes the next address byte match normally.
- R5: For a byte that is not the first after a start, ack_o becomes 1 only in two cases: mode_i is MST_RX (2), or mode_i is SLV_RX (4) with addressed_o = 1. ack_en_i must be 1 in both cases. IDLE (0), MST_TX (1) and SLV_TX (3) give ack_o = 0.
- R6: An address byte that hits neither the own address nor an enabled broadcast gives addressed_o = 0, gen_call_o = 0, ack_o = 0 and no match_o.
- R7: In the master modes (1, 2) the address byte is not compared, and gives ack_o = 0 with no match. The exception is arb_lost_i = 1 with the byte; the byte is then compared as in R2/R3.
- R8: start_i, stop_i or recover_i clear addressed_o and gen_call_o in the next cycle. Any of them takes priority over a byte_valid_i in the same cycle; that byte is dropped and ack_o holds.
- R9: Only the first byte after a start is compared. Later bytes equal to the own address raise no match_o. ack_o and rw_o hold between bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| own_addr_i | input | 8 | Own address in [7:1], broadcast enable in [0] |
| ack_en_i | input | 1 | Acknowledge enable |
| mode_i | input | 3 | 0 IDLE, 1 MST_TX, 2 MST_RX, 3 SLV_TX, 4 SLV_RX |
| arb_lost_i | input | 1 | Arbitration lost during this address byte |
| start_i | input | 1 | Start or repeated start detected |
| stop_i | input | 1 | Stop detected |
| recover_i | input | 1 | Slave recovery command |
| rx_byte_i | input | 8 | Received byte |
| byte_valid_i | input | 1 | rx_byte_i is complete |
| addressed_o | output | 1 | Device is addressed as slave |
| gen_call_o | output | 1 | Addressed through broadcast |
| rw_o | output | 1 | Direction bit of the last matching address |
| match_o | output | 1 | One-cycle address match event |
| ack_o | output | 1 | ACK (1) or NACK (0) for the last byte |

## Verification
The bench checks the 8'h00 broadcast byte with and without its enable. A design that ignored the enable would acknowledge broadcasts it should refuse. It checks address bytes sent while acknowledge is disabled; a wrong design would still claim the bus. It checks master-mode address bytes with and without lost arbitration. Without the arbitration exception a design would either match its own outgoing address or drop the address of a winning master. It also checks a stop arriving together with a byte. It sends data bytes equal to the own address, and a design that compared every byte would pulse match_o on them.

// File: rtl/i2c_addr_ack_pkg.sv
package i2c_addr_ack_pkg;
  localparam int MODE_W = 3;
  typedef enum logic [MODE_W-1:0] {
    MODE_IDLE   = 3'd0,
    MODE_MST_TX = 3'd1,
    MODE_MST_RX = 3'd2,
    MODE_SLV_TX = 3'd3,
    MODE_SLV_RX = 3'd4
  } mode_e;
endpackage

// File: rtl/i2c_addr_cmp.sv
module i2c_addr_cmp #(
  parameter int ADDR_W = 7
) (
  input  logic [ADDR_W:0] own_addr_i,
  input  logic [ADDR_W:0] rx_byte_i,
  output logic            own_hit_o,
  output logic            gc_hit_o
);
  assign own_hit_o = (rx_byte_i[ADDR_W:1] == own_addr_i[ADDR_W:1]);
  // broadcast: whole byte zero, gated by enable bit
  assign gc_hit_o  = (rx_byte_i == '0) && own_addr_i[0];
endmodule

// File: rtl/i2c_data_ack.sv
module i2c_data_ack
  import i2c_addr_ack_pkg::*;
(
  input  mode_e mode_i,
  input  logic  addressed_i,
  input  logic  ack_en_i,
  output logic  ack_o
);
  always_comb begin
    unique case (mode_i)
      MODE_MST_RX: ack_o = ack_en_i;
      MODE_SLV_RX: ack_o = ack_en_i && addressed_i;
      default:     ack_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/i2c_addr_ack.sv
module i2c_addr_ack
  import i2c_addr_ack_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W:0]   own_addr_i,
  input  logic              ack_en_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              arb_lost_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              recover_i,
  input  logic [ADDR_W:0]   rx_byte_i,
  input  logic              byte_valid_i,
  output logic              addressed_o,
  output logic              gen_call_o,
  output logic              rw_o,
  output logic              match_o,
  output logic              ack_o
);
  mode_e mode;
  logic  expect_addr_q;
  logic  own_hit, gc_hit, data_ack;
  logic  ctrl_evt, is_master, may_cmp, hit;

  assign mode      = mode_e'(mode_i);
  assign ctrl_evt  = start_i || stop_i || recover_i;
  assign is_master = (mode == MODE_MST_TX) || (mode == MODE_MST_RX);
  assign may_cmp   = !is_master || arb_lost_i;

  i2c_addr_cmp #(.ADDR_W(ADDR_W)) u_cmp (
    .own_addr_i (own_addr_i),
    .rx_byte_i  (rx_byte_i),
    .own_hit_o  (own_hit),
    .gc_hit_o   (gc_hit)
  );

  i2c_data_ack u_dack (
    .mode_i      (mode),
    .addressed_i (addressed_o),
    .ack_en_i    (ack_en_i),
    .ack_o       (data_ack)
  );

  assign hit = may_cmp && ack_en_i && (own_hit || gc_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      expect_addr_q <= 1'b0;
      addressed_o   <= 1'b0;
      gen_call_o    <= 1'b0;
      rw_o          <= 1'b0;
      match_o       <= 1'b0;
      ack_o         <= 1'b0;
    end else begin
      match_o <= 1'b0;
      if (ctrl_evt) begin
        // bus events win; a byte in the same cycle is dropped
        expect_addr_q <= start_i;
        addressed_o   <= 1'b0;
        gen_call_o    <= 1'b0;
      end else if (byte_valid_i) begin
        if (expect_addr_q) begin
          expect_addr_q <= 1'b0;
          addressed_o   <= hit;
          gen_call_o    <= hit && gc_hit;
          ack_o         <= hit;
          match_o       <= hit;
          if (hit) rw_o <= rx_byte_i[0];
        end else begin
          ack_o <= data_ack;
        end
      end
    end
  end

  AST_MATCH_ACKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> (ack_o && addressed_o)) else $error("match without ack"); // R2
  AST_MATCH_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> !match_o) else $error("match longer than one cycle"); // R9
  AST_GC_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gen_call_o) |-> $past(own_addr_i[0])) else $error("broadcast while disabled"); // R3
  AST_DISCONNECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && !ack_en_i && !ctrl_evt) |=> (!ack_o && !match_o)) else $error("ack while disabled"); // R4
  AST_CTRL_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_evt |=> (!addressed_o && !gen_call_o)) else $error("addressed after bus event"); // R8
  AST_GC_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_call_o |-> addressed_o) else $error("broadcast flag alone"); // R3
endmodule

// File: tb/i2c_addr_ack_test.sv
module i2c_addr_ack_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] own_addr_i = 8'hFE;
  logic       ack_en_i = 1'b0;
  logic [2:0] mode_i = 3'd0;
  logic       arb_lost_i = 1'b0, start_i = 1'b0, stop_i = 1'b0, recover_i = 1'b0;
  logic [7:0] rx_byte_i = 8'h00;
  logic       byte_valid_i = 1'b0;
  logic       addressed_o, gen_call_o, rw_o, match_o, ack_o;

  int n_chk = 0, n_fail = 0;
  logic m_exp = 0, m_adr = 0, m_gc = 0, m_rw = 0, m_match = 0, m_ack = 0;

  always #5 clk_i = ~clk_i;

  i2c_addr_ack uut (.*);

  initial begin
    #1_500_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  function automatic logic ref_hit(logic [7:0] own, logic [7:0] b);
    return (b[7:1] == own[7:1]) || (b == 8'h00 && own[0]);
  endfunction

  function automatic logic ref_dack(logic [2:0] md, logic adr, logic en);
    return en && (md == 3'd2 || (md == 3'd4 && adr));
  endfunction

  // reference update from the requirements, applied for the edge just taken
  task automatic model();
    m_match = 0;
    if (start_i || stop_i || recover_i) begin          // R8
      m_exp = start_i; m_adr = 0; m_gc = 0;
    end else if (byte_valid_i) begin
      if (m_exp) begin                                  // R2 R3 R6 R7
        logic cmp, h;
        m_exp = 0;
        cmp = !(mode_i == 3'd1 || mode_i == 3'd2) || arb_lost_i;
        h = cmp && ack_en_i && ref_hit(own_addr_i, rx_byte_i);
        m_adr = h; m_gc = h && rx_byte_i == 8'h00 && own_addr_i[0];
        m_ack = h; m_match = h;
        if (h) m_rw = rx_byte_i[0];
      end else m_ack = ref_dack(mode_i, m_adr, ack_en_i); // R5
    end
  endtask

  task automatic check(string req);
    logic [4:0] act, exp;
    act = {addressed_o, gen_call_o, rw_o, match_o, ack_o};
    exp = {m_adr, m_gc, m_rw, m_match, m_ack};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {adr,gc,rw,match,ack} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cyc(string req, logic st, logic sp, logic rc, logic bv, logic [7:0] b);
    @(negedge clk_i);
    start_i = st; stop_i = sp; recover_i = rc; byte_valid_i = bv; rx_byte_i = b;
    @(posedge clk_i);
    model();
    @(negedge clk_i);
    check(req);
    start_i = 0; stop_i = 0; recover_i = 0; byte_valid_i = 0;
  endtask

  initial begin
    void'($urandom(32'd4711));
    #23;
    @(negedge clk_i);
    check("R1");
    rst_ni = 1;
    own_addr_i = 8'hA4; ack_en_i = 1; mode_i = 3'd4;
    // R2: own address, read
    cyc("R2", 1, 0, 0, 0, 8'h00);
    cyc("R2", 0, 0, 0, 1, 8'hA5);
    cyc("R9", 0, 0, 0, 0, 8'h00);
    // R9: data equal to own address, no match; R5 SLV_RX addressed acks
    cyc("R9", 0, 0, 0, 1, 8'hA4);
    // R5 other modes
    mode_i = 3'd3; cyc("R5", 0, 0, 0, 1, 8'h11);
    mode_i = 3'd0; cyc("R5", 0, 0, 0, 1, 8'h11);
    mode_i = 3'd2; cyc("R5", 0, 0, 0, 1, 8'h11);
    mode_i = 3'd1; cyc("R5", 0, 0, 0, 1, 8'h11);
    // R8: stop together with byte
    mode_i = 3'd4; cyc("R8", 0, 1, 0, 1, 8'h22);
    // R3: broadcast disabled then enabled
    own_addr_i = 8'hA4; cyc("R3", 1, 0, 0, 0, 8'h00); cyc("R3", 0, 0, 0, 1, 8'h00);
    own_addr_i = 8'hA5; cyc("R3", 1, 0, 0, 0, 8'h00); cyc("R3", 0, 0, 0, 1, 8'h00);
    cyc("R8", 0, 0, 1, 0, 8'h00);
    // R6: mismatch
    cyc("R6", 1, 0, 0, 0, 8'h00); cyc("R6", 0, 0, 0, 1, 8'h36);
    // R4: disconnect, then resume
    ack_en_i = 0; cyc("R4", 1, 0, 0, 0, 8'h00); cyc("R4", 0, 0, 0, 1, 8'hA4);
    mode_i = 3'd2; cyc("R4", 0, 0, 0, 1, 8'h55);
    ack_en_i = 1; mode_i = 3'd4;
    cyc("R4", 1, 0, 0, 0, 8'h00); cyc("R4", 0, 0, 0, 1, 8'hA4);
    // R7: master without and with lost arbitration
    mode_i = 3'd1; cyc("R7", 1, 0, 0, 0, 8'h00); cyc("R7", 0, 0, 0, 1, 8'hA4);
    cyc("R7", 1, 0, 0, 0, 8'h00);
    arb_lost_i = 1; cyc("R7", 0, 0, 0, 1, 8'hA5); arb_lost_i = 0;
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      int r;
      logic [7:0] b;
      if (i % 200 == 0) begin
        own_addr_i = {7'($urandom_range(1, 127)), 1'($urandom)};
        ack_en_i = ($urandom_range(0, 9) != 0);
      end
      mode_i = 3'($urandom_range(0, 4));
      arb_lost_i = ($urandom_range(0, 3) == 0);
      r = $urandom_range(0, 9);
      b = (r < 4) ? {own_addr_i[7:1], 1'($urandom)} : (r < 6) ? 8'h00 : 8'($urandom);
      r = $urandom_range(0, 19);
      cyc("R2 R3 R5 R6 R7 R8 R9", r < 3, r == 3, r == 4, r > 2, b);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule